// File: doc/BRIEF.md
# Fuse Usage-Map Entry Manager

This block looks after the usage map of a one-time-programmable fuse array. The map holds one byte per physical data block; a zero byte means the block is still unused. On command the block allocates (finds the first unused entry and reports its block number), counts the unused entries left, builds and burns the map entry for a logical address, or retires an existing entry by burning one more bit. Fuse bits can only go from 0 to 1, so retiring an entry must spoil its check bits rather than clear it.

The array is reached through a simple 16-bit physical port: the block raises a request with a word address, direction and write data, holds it until the array acknowledges, and never has more than one request in flight. Every command ends with a one-cycle done pulse; scan results stay on the result outputs until the next scan.

Top module: `fusemap_mgr`

## Requirements
- R1: After reset the block is idle: `phy_req` and `done` are 0, `res_blk` is 0xFFFF, `res_count` is 0 and `res_full` is 0.
- R2: A request is held with stable address, direction and write data until `phy_ack`; only one request is outstanding, and every request address is even and lies within 0x2D0..0x2FC.
- R3: Allocate (`cmd_op`=0) reads words upward from 0x2D0; in each word the low byte (even address) is examined before the high byte, the first zero byte wins, and `res_blk` is that byte's address minus 0x2D0 (zero low byte of word 0x2D2 gives 2, zero high byte gives 3); the scan stops at the first hit.
- R4: The high byte of the final word (byte 0x2FD) is never taken as free.
- R5: When no byte is free, `res_blk` becomes 0xFFFF and `res_full` 1; a successful scan clears `res_full`.
- R6: Count (`cmd_op`=3) reports 0x2FC minus the word address plus 1 when the free byte is a low byte, 0x2FC minus the word address when it is a high byte, and 0 when the map is exhausted.
- R7: Encode (`cmd_op`=1) forms entry bits 5:0 from `cmd_laddr` bits 9:4, bit 6 as the inverted XOR of entry bits 0..3 and bit 7 as the inverted XOR of entry bits 2..5, and issues a single write (no read) to word (0x2D0+`cmd_blk`) with bit 0 cleared, the entry in the high byte when `cmd_blk` is odd and in the low byte when even, the other byte zero.
- R8: Invalidate (`cmd_op`=2) reads the word holding entry `cmd_blk`, sets the lowest zero bit among bits 0..6 of that byte, and writes the word back with the other byte unchanged; a byte whose bits 0..6 are all one is written back unchanged.
- R9: Each command produces exactly one one-cycle `done` pulse, with no request pending; `cmd_valid` while a command is running has no effect.
- R10: The result outputs change only together with `done` of an allocate or count; encode and invalidate leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_op | input | 2 | 0 allocate, 1 encode-and-write, 2 invalidate, 3 count |
| cmd_blk | input | 6 | Map entry index for encode and invalidate |
| cmd_laddr | input | 10 | Logical byte address to encode |
| done | output | 1 | One-cycle end-of-command pulse |
| res_blk | output | 16 | Free block number, 0xFFFF when none |
| res_count | output | 6 | Free entries left |
| res_full | output | 1 | Map exhausted |
| phy_req | output | 1 | Physical access request |
| phy_we | output | 1 | Request is a write |
| phy_addr | output | 10 | Even byte address of the 16-bit word |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | Request accepted this cycle |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |

## Verification
A wrong scan pointer shows up as a read at an unexpected word address or as a wrong read count before the done pulse, so a mis-stepped or mis-started scan is visible within one request. A wrong byte choice or check-bit formula appears directly in the write data of the single write that ends encode and invalidate. A stuck or looping controller shows as a missing done pulse or a second pulse, caught within a few hundred cycles, and results that drift outside a done pulse are flagged on the cycle they change.

// File: rtl/fusemap_pkg.sv
`timescale 1ns/1ps
package fusemap_pkg;
   typedef enum logic [1:0] {
      OP_ALLOC  = 2'd0,
      OP_ENCODE = 2'd1,
      OP_INVAL  = 2'd2,
      OP_COUNT  = 2'd3
   } fm_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_DONE
   } fm_state_e;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;
endpackage

// File: rtl/fusemap_entry_enc.sv
`timescale 1ns/1ps
// Builds a map entry: six address bits plus two inverted check bits.
module fusemap_entry_enc #(
   parameter int LADDR_W  = 10,
   parameter int ADDR_LSB = 4
) (
   input  logic [LADDR_W-1:0] laddr,
   output logic [7:0]         entry
);
   localparam int FIELD_W = LADDR_W - ADDR_LSB;

   if (FIELD_W != 6) begin : g_bad_field
      $error("fusemap_entry_enc: address field must be 6 bits");
   end

   logic [5:0] fld;
   assign fld   = laddr[ADDR_LSB +: 6];
   assign entry = {~^fld[5:2], ~^fld[3:0], fld};
endmodule

// File: rtl/fusemap_inval.sv
`timescale 1ns/1ps
// Sets the lowest clear bit among the low BURN_BITS bits of a byte.
module fusemap_inval #(
   parameter int BURN_BITS = 7
) (
   input  logic [7:0] byte_in,
   output logic [7:0] byte_out
);
   if (BURN_BITS < 1 || BURN_BITS > 7) begin : g_bad_bits
      $error("fusemap_inval: BURN_BITS must be 1..7");
   end

   // run[i] is high when every bit below i is already burnt
   logic [BURN_BITS-1:0] run;
   assign run[0] = 1'b1;

   for (genvar i = 1; i < BURN_BITS; i++) begin : g_run
      assign run[i] = run[i-1] & byte_in[i-1];
   end

   for (genvar i = 0; i < BURN_BITS; i++) begin : g_out
      assign byte_out[i] = byte_in[i] | run[i];
   end

   assign byte_out[7:BURN_BITS] = byte_in[7:BURN_BITS];
endmodule

// File: rtl/fusemap_scan_eval.sv
`timescale 1ns/1ps
// Judges one map word during a scan.
module fusemap_scan_eval #(
   parameter int ADDR_W    = 10,
   parameter int MAP_START = 'h2D0,
   parameter int MAP_END   = 'h2FC,
   parameter int BLK_W     = 6,
   parameter int CNT_W     = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       rdata,
   output logic              found,
   output logic [BLK_W-1:0]  blk,
   output logic [CNT_W-1:0]  cnt
);
   logic              lo_free, hi_free;
   logic [ADDR_W-1:0] off, left;

   assign lo_free = (rdata[7:0] == 8'h00);
   assign hi_free = (rdata[15:8] == 8'h00) && (addr != ADDR_W'(MAP_END));
   assign found   = lo_free | hi_free;
   assign off     = addr - ADDR_W'(MAP_START);
   assign left    = ADDR_W'(MAP_END) - addr;
   assign blk     = lo_free ? BLK_W'(off) : BLK_W'(off + ADDR_W'(1));
   assign cnt     = lo_free ? CNT_W'(left + ADDR_W'(1)) : CNT_W'(left);
endmodule

// File: rtl/fusemap_mgr.sv
`timescale 1ns/1ps
module fusemap_mgr import fusemap_pkg::*; #(
   parameter int ADDR_W    = 10,
   parameter int LADDR_W   = 10,
   parameter int MAP_START = 'h2D0,
   parameter int MAP_END   = 'h2FC,
   parameter int RES_W     = 16,
   localparam int N_ENT    = MAP_END - MAP_START + 2,
   localparam int BLK_W    = $clog2(N_ENT),
   localparam int CNT_W    = $clog2(N_ENT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [BLK_W-1:0]   cmd_blk,
   input  logic [LADDR_W-1:0] cmd_laddr,
   output logic               done,
   output logic [RES_W-1:0]   res_blk,
   output logic [CNT_W-1:0]   res_count,
   output logic               res_full,
   output logic               phy_req,
   output logic               phy_we,
   output logic [ADDR_W-1:0]  phy_addr,
   output logic [15:0]        phy_wdata,
   input  logic               phy_ack,
   input  logic [15:0]        phy_rdata
);
   if (MAP_START % 2 != 0 || MAP_END % 2 != 0) begin : g_bad_align
      $error("fusemap_mgr: map bounds must be even");
   end
   if (MAP_END <= MAP_START || MAP_END >= (1 << ADDR_W)) begin : g_bad_range
      $error("fusemap_mgr: map bounds out of range");
   end
   if (RES_W < BLK_W) begin : g_bad_res
      $error("fusemap_mgr: result too narrow");
   end

   fm_state_e         state_q;
   fm_op_e            op_q, op_in;
   logic [ADDR_W-1:0] addr_q, ent_addr, ent_word;
   logic [15:0]       wdata_q, enc_word, inv_word;
   logic              hi_q;
   logic [7:0]        enc_byte, old_byte, new_byte;
   logic              scan_found;
   logic [BLK_W-1:0]  scan_blk;
   logic [CNT_W-1:0]  scan_cnt;

   assign op_in    = fm_op_e'(cmd_op);
   assign ent_addr = ADDR_W'(MAP_START) + ADDR_W'(cmd_blk);
   assign ent_word = {ent_addr[ADDR_W-1:1], 1'b0};

   fusemap_entry_enc #(.LADDR_W(LADDR_W), .ADDR_LSB(4)) u_enc (
      .laddr (cmd_laddr),
      .entry (enc_byte)
   );
   assign enc_word = ent_addr[0] ? {enc_byte, 8'h00} : {8'h00, enc_byte};

   assign old_byte = hi_q ? phy_rdata[15:8] : phy_rdata[7:0];
   fusemap_inval #(.BURN_BITS(7)) u_inval (
      .byte_in  (old_byte),
      .byte_out (new_byte)
   );
   assign inv_word = hi_q ? {new_byte, phy_rdata[7:0]} : {phy_rdata[15:8], new_byte};

   fusemap_scan_eval #(
      .ADDR_W(ADDR_W), .MAP_START(MAP_START), .MAP_END(MAP_END),
      .BLK_W(BLK_W), .CNT_W(CNT_W)
   ) u_scan (
      .addr  (addr_q),
      .rdata (phy_rdata),
      .found (scan_found),
      .blk   (scan_blk),
      .cnt   (scan_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_ALLOC;
         addr_q    <= '0;
         wdata_q   <= '0;
         hi_q      <= 1'b0;
         res_blk   <= '1;
         res_count <= '0;
         res_full  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (cmd_valid) begin
               op_q <= op_in;
               hi_q <= ent_addr[0];
               case (op_in)
                  OP_ENCODE: begin
                     addr_q  <= ent_word;
                     wdata_q <= enc_word;
                     state_q <= ST_WR;
                  end
                  OP_INVAL: begin
                     addr_q  <= ent_word;
                     state_q <= ST_RD;
                  end
                  default: begin
                     addr_q  <= ADDR_W'(MAP_START);
                     state_q <= ST_RD;
                  end
               endcase
            end
            ST_RD: if (phy_ack) begin
               if (op_q == OP_INVAL) begin
                  wdata_q <= inv_word;
                  state_q <= ST_WR;
               end else if (scan_found) begin
                  res_blk   <= RES_W'(scan_blk);
                  res_count <= scan_cnt;
                  res_full  <= 1'b0;
                  state_q   <= ST_DONE;
               end else if (addr_q == ADDR_W'(MAP_END)) begin
                  res_blk   <= '1;
                  res_count <= '0;
                  res_full  <= 1'b1;
                  state_q   <= ST_DONE;
               end else begin
                  addr_q <= addr_q + ADDR_W'(2);
               end
            end
            ST_WR: if (phy_ack) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign phy_req   = (state_q == ST_RD) || (state_q == ST_WR);
   assign phy_we    = (state_q == ST_WR);
   assign phy_addr  = addr_q;
   assign phy_wdata = wdata_q;
   assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/fusemap_mgr_chk.sv
`timescale 1ns/1ps
module fusemap_mgr_chk #(
   parameter int ADDR_W    = 10,
   parameter int MAP_START = 'h2D0,
   parameter int MAP_END   = 'h2FC,
   parameter int RES_W     = 16,
   parameter int CNT_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic [RES_W-1:0]  res_blk,
   input logic [CNT_W-1:0]  res_count,
   input logic              res_full,
   input logic              phy_req,
   input logic              phy_we,
   input logic [ADDR_W-1:0] phy_addr,
   input logic [15:0]       phy_wdata,
   input logic              phy_ack
);
   localparam int N_ENT = MAP_END - MAP_START + 2;

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

   assert_addr_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req |-> (!phy_addr[0] && phy_addr >= ADDR_W'(MAP_START) && phy_addr <= ADDR_W'(MAP_END)));

   assert_high_end_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_blk != RES_W'(N_ENT - 1));

   assert_full_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_full |-> (res_blk == '1));

   assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_full |-> (res_count == '0));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !phy_req);

   assert_result_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_blk != $past(res_blk) || res_count != $past(res_count)) |-> done);
endmodule

bind fusemap_mgr fusemap_mgr_chk #(
   .ADDR_W(ADDR_W), .MAP_START(MAP_START), .MAP_END(MAP_END),
   .RES_W(RES_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .res_blk(res_blk),
   .res_count(res_count), .res_full(res_full), .phy_req(phy_req),
   .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
   .phy_ack(phy_ack)
);

// File: tb/fusemap_mgr_tb.sv
`timescale 1ns/1ps
module fusemap_mgr_tb;
   localparam int START = 'h2D0;
   localparam int NW    = 23;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [5:0]  cmd_blk = '0;
   logic [9:0]  cmd_laddr = '0;
   logic        done, res_full, phy_req, phy_we;
   logic [15:0] res_blk, phy_wdata;
   logic [5:0]  res_count;
   logic [9:0]  phy_addr;
   logic        phy_ack = 1'b0;
   logic [15:0] phy_rdata = '0;

   logic [15:0] fmem [0:NW-1];
   int n_rd, n_wr, bad_addr, n_chk, n_fail, ndone;
   logic [9:0]  first_raddr, last_waddr;
   logic [15:0] last_wdata;
   bit finished = 1'b0;

   fusemap_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_blk(cmd_blk), .cmd_laddr(cmd_laddr), .done(done),
      .res_blk(res_blk), .res_count(res_count), .res_full(res_full),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
      .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
   );

   always #4 clk = ~clk;   // 125 MHz

   // fuse array model: acknowledges one cycle after a request, burns by OR
   initial begin
      int idx;
      forever begin
         @(negedge clk);
         if (phy_req && !phy_ack) begin
            idx = (int'(phy_addr) - START) / 2;
            if (idx < 0 || idx >= NW || phy_addr[0]) bad_addr++;
            else if (phy_we) begin
               fmem[idx] = fmem[idx] | phy_wdata;
               n_wr++; last_waddr = phy_addr; last_wdata = phy_wdata;
            end else begin
               phy_rdata = fmem[idx];
               if (n_rd == 0) first_raddr = phy_addr;
               n_rd++;
            end
            phy_ack = 1'b1;
         end else phy_ack = 1'b0;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [15:0] v);
      for (int i = 0; i < NW; i++) fmem[i] = v;
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [5:0] blk, input logic [9:0] la);
      int post;
      n_rd = 0; n_wr = 0; bad_addr = 0; first_raddr = '1; ndone = 0; post = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk; cmd_laddr = la;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (done) ndone++;
         if (ndone > 0) post++;
         if (post > 3) break;
      end
      chk("R9", "done pulses", ndone, 1);
      chk("R2", "illegal addresses", bad_addr, 0);
   endtask

   task automatic t_reset;
      chk("R1", "res_blk", res_blk, 16'hFFFF);
      chk("R1", "res_count", res_count, 0);
      chk("R1", "res_full", res_full, 0);
      chk("R1", "phy_req", phy_req, 0);
      chk("R1", "done", done, 0);
   endtask

   task automatic t_alloc_empty;
      fill(16'h0000);
      run_cmd(2'd0, '0, '0);
      chk("R3", "empty blk", res_blk, 0);
      chk("R3", "empty reads", n_rd, 1);
      chk("R3", "first read", first_raddr, 10'h2D0);
      chk("R5", "empty full", res_full, 0);
      run_cmd(2'd3, '0, '0);
      chk("R6", "empty count", res_count, 45);
   endtask

   task automatic t_alloc_high;
      fill(16'hFFFF);
      fmem[0] = 16'h1234; fmem[1] = 16'h0055;
      run_cmd(2'd0, '0, '0);
      chk("R3", "high byte blk", res_blk, 3);
      chk("R3", "high byte reads", n_rd, 2);
      run_cmd(2'd3, '0, '0);
      chk("R6", "high byte count", res_count, 42);
      fmem[1] = 16'h5500;
      run_cmd(2'd0, '0, '0);
      chk("R3", "low byte blk", res_blk, 2);
      chk("R6", "low byte count", res_count, 43);
   endtask

   task automatic t_exhaust;
      fill(16'hFFFF);
      fmem[NW-1] = 16'h00A5;
      run_cmd(2'd0, '0, '0);
      chk("R4", "end high rejected blk", res_blk, 16'hFFFF);
      chk("R5", "full flag", res_full, 1);
      chk("R3", "full reads", n_rd, NW);
      run_cmd(2'd3, '0, '0);
      chk("R6", "full count", res_count, 0);
      fmem[NW-1] = 16'hA500;
      run_cmd(2'd0, '0, '0);
      chk("R3", "last low blk", res_blk, 44);
      chk("R5", "full cleared", res_full, 0);
      chk("R6", "last low count", res_count, 1);
   endtask

   task automatic t_encode;
      logic [15:0] b0;
      logic [5:0]  c0;
      b0 = res_blk; c0 = res_count;
      fill(16'h0000);
      run_cmd(2'd1, 6'd5, 10'h2B0);
      chk("R7", "odd blk addr", last_waddr, 10'h2D4);
      chk("R7", "odd blk data", last_wdata, 16'hAB00);
      chk("R7", "no reads", n_rd, 0);
      chk("R7", "one write", n_wr, 1);
      chk("R10", "blk kept", res_blk, b0);
      chk("R10", "count kept", res_count, c0);
      run_cmd(2'd1, 6'd0, 10'h3F0);
      chk("R7", "all ones data", {last_waddr, last_wdata}, {10'h2D0, 16'h00FF});
      run_cmd(2'd1, 6'd44, 10'h010);
      chk("R7", "last entry data", {last_waddr, last_wdata}, {10'h2FC, 16'h0081});
   endtask

   task automatic t_inval;
      logic [15:0] b0;
      b0 = res_blk;
      fill(16'h0000);
      fmem[3] = 16'h12AB;
      run_cmd(2'd2, 6'd6, '0);
      chk("R8", "low burn", {last_waddr, last_wdata}, {10'h2D6, 16'h12AF});
      chk("R8", "rd/wr", {n_rd[7:0], n_wr[7:0]}, {8'd1, 8'd1});
      fmem[5] = 16'h0F34;
      run_cmd(2'd2, 6'd11, '0);
      chk("R8", "high burn", {last_waddr, last_wdata}, {10'h2DA, 16'h1F34});
      fmem[5] = 16'h34FF;
      run_cmd(2'd2, 6'd10, '0);
      chk("R8", "saturated", {last_waddr, last_wdata}, {10'h2DA, 16'h34FF});
      chk("R10", "blk kept inval", res_blk, b0);
   endtask

   task automatic t_busy;
      int post;
      fill(16'hFFFF);
      fmem[20] = 16'h0000;
      n_rd = 0; n_wr = 0; ndone = 0; post = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd0;
      @(negedge clk);
      cmd_op = 2'd1; cmd_blk = 6'd3; cmd_laddr = 10'h3F0;
      repeat (6) @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (done) ndone++;
         if (ndone > 0) post++;
         if (post > 3) break;
      end
      chk("R9", "busy done pulses", ndone, 1);
      chk("R9", "busy writes", n_wr, 0);
      chk("R3", "busy blk", res_blk, 40);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      fill(16'h0000);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_alloc_empty;
      t_alloc_high;
      t_exhaust;
      t_encode;
      t_inval;
      t_busy;
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule